// File: doc/BRIEF.md
# Condition Code Unit

This unit turns the outcome of an integer operation into the 2-bit condition code of a mainframe-style processor. A five-bit selector names the operation class. Three 64-bit operands come with it: a first operand (`src`), a second operand (`dst`) and the result that the datapath already computed (`res`). The unit compares, inspects signs and detects overflow or carry, then writes one code from 0 to 3. Many selectors lead to the same code value, and the meaning of each value depends on the class.

Compare, arithmetic, absolute-value, complement, test-under-mask, nonzero and literal classes are covered. Most classes have a 32-bit form, which looks only at the low halves of the operands. A selector outside the table raises an error flag and forces the code to 0. By default the result is registered, so it appears one clock after the request. The `REG_OUT` parameter set to 0 gives a purely combinational path.

Top module: `cond_code_unit`

## Requirements
- R1: While `in_valid` is low, and after reset, the outputs `out_valid`, `cc` and `err` are 0. With `REG_OUT`=1 (the default), `out_valid`, `cc` and `err` reflect the request presented one clock earlier.
- R2: Compares (selector 3 signed 32-bit, 4 signed 64-bit, 5 unsigned 32-bit, 6 unsigned 64-bit) compare `src` against `dst`. They give 0 when the operands are equal, 1 when `src` is lower and 2 when `src` is higher. The 32-bit forms use bits 31:0 only.
- R3: Compare with zero (selector 1 on bits 31:0, selector 2 on all 64 bits) compares `dst` as a signed number against zero: 0 for zero, 1 for negative, 2 for positive.
- R4: Signed add (10 for 64-bit, 17 for 32-bit) and signed subtract (12, 19) treat `src` and `dst` as the operands and `res` as the result. The code is 3 on overflow. Add overflows when two strictly positive operands give a negative result, or two negative operands give a strictly positive one. Subtract overflows when positive minus negative is negative, or negative minus positive is positive. Without overflow the code is 0 for a zero `res`, 1 for a negative `res` and 2 for a positive `res`.
- R5: Logical add (11, 18) sees a carry when `res` is unsigned-below `src` or below `dst`. The code is 0 for zero with no carry, 1 for nonzero with no carry, 2 for zero with carry and 3 for nonzero with carry.
- R6: Logical subtract (13, 20) gives 2 when `res` is zero. Otherwise it gives 1 when `dst` is unsigned-above `src` (a borrow), and 3 in the remaining case.
- R7: Load absolute (14, and 21 for 32-bit) gives 3 when `dst` equals 0x8000_0000_0000_0000, 0 when it is zero, and 2 otherwise. Selector 21 evaluates all 64 bits of `dst`, exactly like selector 14.
- R8: Load negative absolute (15, and 22 for 32-bit) gives 0 for a zero `dst` and 1 otherwise. Both selectors evaluate all 64 bits.
- R9: Load complement (16 for 64-bit, 23 on bits 31:0) gives 3 when `dst` is the most negative value of its width, and otherwise 0, 1 or 2 for zero, negative or positive.
- R10: Test under mask (7 and 8, same behaviour) uses `dst[15:0]` as the mask and `src[15:0]` as the value. When the masked value is zero or the mask is zero, the code is 0. When the masked value equals the mask, the code is 3. Otherwise the unit finds the highest set bit of the mask: the code is 2 if the value has that bit set and 1 if not.
- R11: Nonzero test (9) gives 0 when all 64 bits of `dst` are zero and 1 otherwise.
- R12: Literal (0) passes `dst[1:0]` straight to the code.
- R13: A selector from 24 to 31 with `in_valid` high sets `err` and forces `cc` to 0. Every known selector leaves `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 5 | Operation class selector |
| src | input | 64 | First operand / tested value |
| dst | input | 64 | Second operand / mask / single operand |
| res | input | 64 | Result computed by the datapath |
| out_valid | output | 1 | Code is valid |
| cc | output | 2 | Condition code |
| err | output | 1 | Unknown selector |

## Verification
The hardest situations to reach are the overflow corners and the mixed test-under-mask case. Overflow needs operand and result signs that only a wrapped sum produces. The mixed case needs a mask whose leftmost bit differs from the value while other masked bits match. Directed steps build these cases from extreme values such as the largest positive number, the most negative number and split masks. A long run of random selectors then feeds consistent operand pairs with their true sum or difference, so that overflow and carry arise naturally, and compares every clock against the behavioural model.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    typedef enum logic [4:0] {
        OP_LIT    = 5'd0,
        OP_CMPZ32 = 5'd1,
        OP_CMPZ64 = 5'd2,
        OP_CMPS32 = 5'd3,
        OP_CMPS64 = 5'd4,
        OP_CMPU32 = 5'd5,
        OP_CMPU64 = 5'd6,
        OP_TM32   = 5'd7,
        OP_TM64   = 5'd8,
        OP_NZ     = 5'd9,
        OP_ADD64  = 5'd10,
        OP_ADDU64 = 5'd11,
        OP_SUB64  = 5'd12,
        OP_SUBU64 = 5'd13,
        OP_ABS64  = 5'd14,
        OP_NABS64 = 5'd15,
        OP_COMP64 = 5'd16,
        OP_ADD32  = 5'd17,
        OP_ADDU32 = 5'd18,
        OP_SUB32  = 5'd19,
        OP_SUBU32 = 5'd20,
        OP_ABS32  = 5'd21,
        OP_NABS32 = 5'd22,
        OP_COMP32 = 5'd23
    } ccu_op_e;

    localparam int unsigned CCU_LAST_OP = 23;

    typedef enum logic [1:0] {
        UK_ABS  = 2'd0,
        UK_NABS = 2'd1,
        UK_COMP = 2'd2,
        UK_NZ   = 2'd3
    } ccu_ukind_e;

    typedef enum logic [2:0] {
        U_LIT   = 3'd0,
        U_CMP   = 3'd1,
        U_ARITH = 3'd2,
        U_UNARY = 3'd3,
        U_TM    = 3'd4
    } ccu_unit_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] code;
        logic       err;
    } ccu_out_t;

endpackage

// File: rtl/ccu_cmp.sv
module ccu_cmp #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    input  logic          is_signed,
    output logic [1:0]    code
);
    localparam int HW = DW / 2;

    logic signed [DW:0] ext_a;
    logic signed [DW:0] ext_b;

    always_comb begin
        if (wide) begin
            ext_a = {is_signed & a[DW-1], a};
            ext_b = {is_signed & b[DW-1], b};
        end else begin
            ext_a = {{(HW+1){is_signed & a[HW-1]}}, a[HW-1:0]};
            ext_b = {{(HW+1){is_signed & b[HW-1]}}, b[HW-1:0]};
        end
        if (ext_a == ext_b) begin
            code = 2'd0;
        end else if (ext_a < ext_b) begin
            code = 2'd1;
        end else begin
            code = 2'd2;
        end
    end

endmodule

// File: rtl/ccu_arith.sv
module ccu_arith #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] r,
    input  logic          wide,
    input  logic          is_sub,
    input  logic          is_logical,
    output logic [1:0]    code
);
    localparam int HW = DW / 2;

    logic [DW-1:0] xa, xb, xr;
    logic neg_a, neg_b, neg_r;
    logic pos_a, pos_b, pos_r;
    logic zero_r, ovf, carry;

    function automatic logic [DW-1:0] narrow(input logic [DW-1:0] v,
                                             input logic w,
                                             input logic logical);
        logic [DW-1:0] o;
        if (w) begin
            o = v;
        end else begin
            o = {{HW{(!logical) & v[HW-1]}}, v[HW-1:0]};
        end
        return o;
    endfunction

    always_comb begin
        xa = narrow(a, wide, is_logical);
        xb = narrow(b, wide, is_logical);
        xr = narrow(r, wide, is_logical);

        neg_a  = xa[DW-1];
        neg_b  = xb[DW-1];
        neg_r  = xr[DW-1];
        pos_a  = !xa[DW-1] && (xa != '0);
        pos_b  = !xb[DW-1] && (xb != '0);
        pos_r  = !xr[DW-1] && (xr != '0);
        zero_r = (xr == '0);

        if (is_sub) begin
            ovf = (pos_a && neg_b && neg_r) || (neg_a && pos_b && pos_r);
        end else begin
            ovf = (pos_a && pos_b && neg_r) || (neg_a && neg_b && pos_r);
        end
        carry = (xr < xa) || (xr < xb);

        if (!is_logical) begin
            if (ovf) begin
                code = 2'd3;
            end else if (zero_r) begin
                code = 2'd0;
            end else if (neg_r) begin
                code = 2'd1;
            end else begin
                code = 2'd2;
            end
        end else if (!is_sub) begin
            code = {carry, !zero_r};
        end else if (zero_r) begin
            code = 2'd2;
        end else if (xb > xa) begin
            code = 2'd1;
        end else begin
            code = 2'd3;
        end
    end

endmodule

// File: rtl/ccu_unary.sv
module ccu_unary
    import ccu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] x,
    input  logic          wide,
    input  ccu_ukind_e    kind,
    output logic [1:0]    code
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};
    localparam logic [HW-1:0] MIN_H = {1'b1, {(HW-1){1'b0}}};

    logic is_zero, is_neg, is_min;

    always_comb begin
        is_zero = wide ? (x == '0) : (x[HW-1:0] == '0);
        is_neg  = wide ? x[DW-1] : x[HW-1];
        is_min  = wide ? (x == MIN_W) : (x[HW-1:0] == MIN_H);

        case (kind)
            UK_ABS:  code = is_min ? 2'd3 : (is_zero ? 2'd0 : 2'd2);
            UK_NABS: code = is_zero ? 2'd0 : 2'd1;
            UK_COMP: begin
                if (is_min) begin
                    code = 2'd3;
                end else if (is_zero) begin
                    code = 2'd0;
                end else if (is_neg) begin
                    code = 2'd1;
                end else begin
                    code = 2'd2;
                end
            end
            default: code = is_zero ? 2'd0 : 2'd1;
        endcase
    end

endmodule

// File: rtl/ccu_tm.sv
module ccu_tm #(
    parameter int MW = 16
) (
    input  logic [MW-1:0] val,
    input  logic [MW-1:0] mask,
    output logic [1:0]    code
);
    logic [MW-1:0] sel;
    logic          lead;
    logic          found;

    always_comb begin
        sel   = val & mask;
        lead  = 1'b0;
        found = 1'b0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (!found && mask[i]) begin
                lead  = val[i];
                found = 1'b1;
            end
        end
        if (sel == '0) begin
            code = 2'd0;
        end else if (sel == mask) begin
            code = 2'd3;
        end else if (lead) begin
            code = 2'd2;
        end else begin
            code = 2'd1;
        end
    end

endmodule

// File: rtl/cond_code_unit.sv
module cond_code_unit
    import ccu_pkg::*;
#(
    parameter int DW      = 64,
    parameter int MW      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [4:0]    op_sel,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] res,
    output logic          out_valid,
    output logic [1:0]    cc,
    output logic          err
);
    ccu_op_e    op;
    ccu_unit_e  unit;
    logic       known;

    logic [DW-1:0] cmp_a, cmp_b;
    logic          cmp_wide, cmp_sgn;
    logic [1:0]    cmp_code;

    logic          ar_wide, ar_sub, ar_log;
    logic [1:0]    ar_code;

    logic          un_wide;
    ccu_ukind_e    un_kind;
    logic [1:0]    un_code;

    logic [1:0]    tm_code;
    logic [1:0]    pick;

    ccu_out_t out_d, out_q;

    assign op = ccu_op_e'(op_sel);

    always_comb begin
        unit     = U_LIT;
        known    = 1'b1;
        cmp_a    = src;
        cmp_b    = dst;
        cmp_wide = 1'b1;
        cmp_sgn  = 1'b1;
        ar_wide  = 1'b1;
        ar_sub   = 1'b0;
        ar_log   = 1'b0;
        un_wide  = 1'b1;
        un_kind  = UK_NZ;
        case (op)
            OP_LIT:    unit = U_LIT;
            OP_CMPZ32: begin unit = U_CMP; cmp_a = dst; cmp_b = '0; cmp_wide = 1'b0; end
            OP_CMPZ64: begin unit = U_CMP; cmp_a = dst; cmp_b = '0; end
            OP_CMPS32: begin unit = U_CMP; cmp_wide = 1'b0; end
            OP_CMPS64: unit = U_CMP;
            OP_CMPU32: begin unit = U_CMP; cmp_wide = 1'b0; cmp_sgn = 1'b0; end
            OP_CMPU64: begin unit = U_CMP; cmp_sgn = 1'b0; end
            OP_TM32,
            OP_TM64:   unit = U_TM;
            OP_NZ:     begin unit = U_UNARY; un_kind = UK_NZ; end
            OP_ADD64:  unit = U_ARITH;
            OP_ADDU64: begin unit = U_ARITH; ar_log = 1'b1; end
            OP_SUB64:  begin unit = U_ARITH; ar_sub = 1'b1; end
            OP_SUBU64: begin unit = U_ARITH; ar_sub = 1'b1; ar_log = 1'b1; end
            OP_ABS64,
            OP_ABS32:  begin unit = U_UNARY; un_kind = UK_ABS; end
            OP_NABS64,
            OP_NABS32: begin unit = U_UNARY; un_kind = UK_NABS; end
            OP_COMP64: begin unit = U_UNARY; un_kind = UK_COMP; end
            OP_COMP32: begin unit = U_UNARY; un_kind = UK_COMP; un_wide = 1'b0; end
            OP_ADD32:  begin unit = U_ARITH; ar_wide = 1'b0; end
            OP_ADDU32: begin unit = U_ARITH; ar_wide = 1'b0; ar_log = 1'b1; end
            OP_SUB32:  begin unit = U_ARITH; ar_wide = 1'b0; ar_sub = 1'b1; end
            OP_SUBU32: begin
                unit    = U_ARITH;
                ar_wide = 1'b0;
                ar_sub  = 1'b1;
                ar_log  = 1'b1;
            end
            default:   known = 1'b0;
        endcase
    end

    ccu_cmp #(.DW(DW)) u_cmp (
        .a         (cmp_a),
        .b         (cmp_b),
        .wide      (cmp_wide),
        .is_signed (cmp_sgn),
        .code      (cmp_code)
    );

    ccu_arith #(.DW(DW)) u_arith (
        .a          (src),
        .b          (dst),
        .r          (res),
        .wide       (ar_wide),
        .is_sub     (ar_sub),
        .is_logical (ar_log),
        .code       (ar_code)
    );

    ccu_unary #(.DW(DW)) u_unary (
        .x    (dst),
        .wide (un_wide),
        .kind (un_kind),
        .code (un_code)
    );

    ccu_tm #(.MW(MW)) u_tm (
        .val  (src[MW-1:0]),
        .mask (dst[MW-1:0]),
        .code (tm_code)
    );

    always_comb begin
        case (unit)
            U_CMP:   pick = cmp_code;
            U_ARITH: pick = ar_code;
            U_UNARY: pick = un_code;
            U_TM:    pick = tm_code;
            default: pick = dst[1:0];
        endcase
        out_d.vld  = in_valid;
        out_d.err  = in_valid && !known;
        out_d.code = (in_valid && known) ? pick : 2'd0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign out_valid = out_q.vld;
    assign cc        = out_q.code;
    assign err       = out_q.err;

endmodule

// File: rtl/ccu_chk.sv
module ccu_chk #(
    parameter int DW      = 64,
    parameter int MW      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [4:0]    op_sel,
    input logic [DW-1:0] src,
    input logic [DW-1:0] dst,
    input logic [DW-1:0] res,
    input logic          out_valid,
    input logic [1:0]    cc,
    input logic          err
);
    logic          s_v;
    logic [4:0]    s_op;
    logic [DW-1:0] s_src, s_dst, s_res;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_v   <= 1'b0;
                    s_op  <= '0;
                    s_src <= '0;
                    s_dst <= '0;
                    s_res <= '0;
                end else begin
                    s_v   <= in_valid;
                    s_op  <= op_sel;
                    s_src <= src;
                    s_dst <= dst;
                    s_res <= res;
                end
            end
        end else begin : g_now
            assign s_v   = in_valid;
            assign s_op  = op_sel;
            assign s_src = src;
            assign s_dst = dst;
            assign s_res = res;
        end
    endgenerate

    logic add_ovf;
    always_comb begin
        add_ovf = (!s_src[DW-1] && s_src != '0 && !s_dst[DW-1] && s_dst != '0 && s_res[DW-1])
               || (s_src[DW-1] && s_dst[DW-1] && !s_res[DW-1] && s_res != '0);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (cc == 2'd0 && !err)); // R1
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == s_v); // R1
    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err) |-> cc == 2'd0); // R13
    AST_KNOWN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && s_op <= 5'd23) |-> !err); // R13
    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && s_op == 5'd10 && add_ovf) |-> cc == 2'd3); // R4
    AST_TM_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && (s_op == 5'd7 || s_op == 5'd8) && s_dst[MW-1:0] == '0) |-> cc == 2'd0); // R10
    AST_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && s_op == 5'd0) |-> cc == s_dst[1:0]); // R12
    AST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && s_op == 5'd9) |-> cc == ((s_dst != '0) ? 2'd1 : 2'd0)); // R11

endmodule

bind cond_code_unit ccu_chk #(.DW(DW), .MW(MW), .REG_OUT(REG_OUT)) u_ccu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src       (src),
    .dst       (dst),
    .res       (res),
    .out_valid (out_valid),
    .cc        (cc),
    .err       (err)
);

// File: tb/cond_code_unit_bench.sv
module cond_code_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [63:0] src = '0, dst = '0, res = '0;
    logic        out_valid;
    logic [1:0]  cc;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit    exp_v = 1'b0;
    int    exp_cc = 0;
    bit    exp_err = 1'b0;
    string exp_tag = "R1";

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    cond_code_unit u_cond_code_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src(src), .dst(dst), .res(res),
        .out_valid(out_valid), .cc(cc), .err(err)
    );

    function automatic int sign3(input longint v);
        if (v == 0) return 0;
        if (v < 0) return 1;
        return 2;
    endfunction

    function automatic void model(input int op, input logic [63:0] s, d, r,
                                  output int code, output bit bad);
        longint sa = s, da = d, ra = r;
        int s32 = s[31:0], d32 = d[31:0], r32 = r[31:0];
        logic [15:0] m, v;
        bit c;
        bad = 1'b0;
        code = 0;
        case (op)
            0:  code = int'(d[1:0]);
            1:  code = sign3(longint'(d32));
            2:  code = sign3(da);
            3:  code = (s32 == d32) ? 0 : (s32 < d32) ? 1 : 2;
            4:  code = (sa == da) ? 0 : (sa < da) ? 1 : 2;
            5:  code = (s[31:0] == d[31:0]) ? 0 : (s[31:0] < d[31:0]) ? 1 : 2;
            6:  code = (s == d) ? 0 : (s < d) ? 1 : 2;
            7, 8: begin
                m = d[15:0];
                v = s[15:0];
                if ((v & m) == 0) code = 0;
                else if ((v & m) == m) code = 3;
                else begin
                    int k = 15;
                    while (!m[k]) k--;
                    code = v[k] ? 2 : 1;
                end
            end
            9:  code = (d != 0) ? 1 : 0;
            10: code = ((sa > 0 && da > 0 && ra < 0) || (sa < 0 && da < 0 && ra > 0)) ? 3 : sign3(ra);
            17: code = ((s32 > 0 && d32 > 0 && r32 < 0) || (s32 < 0 && d32 < 0 && r32 > 0)) ? 3 : sign3(longint'(r32));
            12: code = ((sa > 0 && da < 0 && ra < 0) || (sa < 0 && da > 0 && ra > 0)) ? 3 : sign3(ra);
            19: code = ((s32 > 0 && d32 < 0 && r32 < 0) || (s32 < 0 && d32 > 0 && r32 > 0)) ? 3 : sign3(longint'(r32));
            11: begin c = (r < s) || (r < d); code = (c ? 2 : 0) + ((r != 0) ? 1 : 0); end
            18: begin
                c = (r[31:0] < s[31:0]) || (r[31:0] < d[31:0]);
                code = (c ? 2 : 0) + ((r[31:0] != 0) ? 1 : 0);
            end
            13: code = (r == 0) ? 2 : (d > s) ? 1 : 3;
            20: code = (r[31:0] == 0) ? 2 : (d[31:0] > s[31:0]) ? 1 : 3;
            14, 21: code = (d == MIN64) ? 3 : (d != 0) ? 2 : 0;
            15, 22: code = (d != 0) ? 1 : 0;
            16: code = (d == MIN64) ? 3 : sign3(da);
            23: code = (d[31:0] == 32'h8000_0000) ? 3 : sign3(longint'(d32));
            default: begin bad = 1'b1; code = 0; end
        endcase
    endfunction

    task automatic compare_now();
        checks++;
        if (out_valid !== exp_v || int'(cc) != exp_cc || err !== exp_err) begin
            errors++;
            $display("FAIL %s: got v=%0b cc=%0d err=%0b, expected v=%0b cc=%0d err=%0b",
                     exp_tag, out_valid, cc, err, exp_v, exp_cc, exp_err);
        end
    endtask

    task automatic step(input bit v, input int op, input logic [63:0] s, d, r,
                        input string tag);
        int c;
        bit b;
        @(negedge clk);
        compare_now();
        in_valid = v;
        op_sel   = op[4:0];
        src      = s;
        dst      = d;
        res      = r;
        model(op, s, d, r, c, b);
        exp_v   = v;
        exp_cc  = v ? c : 0;
        exp_err = v ? b : 1'b0;
        exp_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_now();                                   // R1 reset state
        rst_n = 1'b1;
        step(0, 4, 64'd1, 64'd2, 64'd0, "R1");
        // R12 literal
        step(1, 0, 0, 64'd2, 0, "R12");
        step(1, 0, 0, 64'hF7, 0, "R12");
        // R2 compares
        step(1, 4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R2");
        step(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R2");
        step(1, 3, 64'hFFFF_FFFF_0000_0005, 64'd5, 0, "R2");
        step(1, 5, 64'h8000_0000, 64'd1, 0, "R2");
        step(1, 3, 64'h8000_0000, 64'd1, 0, "R2");
        // R3 compare with zero
        step(1, 1, 0, 64'h1_0000_0000, 0, "R3");
        step(1, 2, 0, 64'h1_0000_0000, 0, "R3");
        step(1, 1, 0, 64'h8000_0000, 0, "R3");
        // R4 signed add/sub
        step(1, 10, MAX64, 64'd1, MIN64, "R4");
        step(1, 10, '1, '1, 64'hFFFF_FFFF_FFFF_FFFE, "R4");
        step(1, 17, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, "R4");
        step(1, 12, MAX64, '1, MIN64, "R4");
        step(1, 19, 0, 0, 0, "R4");
        step(1, 12, MIN64, 64'd1, MAX64, "R4");
        // R5 logical add
        step(1, 11, '1, 64'd1, 64'd0, "R5");
        step(1, 11, '1, 64'd2, 64'd1, "R5");
        step(1, 11, 64'd1, 64'd2, 64'd3, "R5");
        step(1, 11, 0, 0, 0, "R5");
        step(1, 18, 64'hFFFF_FFFF, 64'd1, 64'h1_0000_0000, "R5");
        // R6 logical subtract
        step(1, 13, 64'd3, 64'd3, 64'd0, "R6");
        step(1, 13, 64'd2, 64'd3, '1, "R6");
        step(1, 13, 64'd5, 64'd3, 64'd2, "R6");
        step(1, 20, 64'h1_0000_0002, 64'd3, 64'hFFFF_FFFF, "R6");
        // R7 absolute
        step(1, 14, 0, MIN64, 0, "R7");
        step(1, 21, 0, 64'h8000_0000, 0, "R7");
        step(1, 14, 0, 0, 0, "R7");
        step(1, 21, 0, 64'h1_0000_0000, 0, "R7");
        // R8 negative absolute
        step(1, 15, 0, 0, 0, "R8");
        step(1, 22, 0, 64'h1_0000_0000, 0, "R8");
        // R9 complement
        step(1, 16, 0, MIN64, 0, "R9");
        step(1, 23, 0, 64'hFFFF_FFFF_8000_0000, 0, "R9");
        step(1, 23, 0, 64'h1_0000_0000, 0, "R9");
        step(1, 16, 0, 64'hFFFF_FFFF_FFFF_FFFB, 0, "R9");
        step(1, 23, 0, 64'h7, 0, "R9");
        // R10 test under mask
        step(1, 8, '1, 64'h0, 0, "R10");
        step(1, 7, 64'hFFFF, 64'h00F0, 0, "R10");
        step(1, 8, 64'h8000, 64'h8001, 0, "R10");
        step(1, 7, 64'h0001, 64'h8001, 0, "R10");
        step(1, 8, '1, 64'h1_0000, 0, "R10");
        step(1, 8, 64'h0400, 64'h0C00, 0, "R10");
        // R11 nonzero
        step(1, 9, 0, 64'h8000_0000_0000_0000, 0, "R11");
        step(1, 9, 0, 0, 0, "R11");
        // R13 unknown selectors, then idle
        step(1, 24, 0, 64'd3, 0, "R13");
        step(1, 31, '1, '1, '1, "R13");
        step(0, 31, '1, '1, '1, "R1");
        // random sweep over all selectors
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] a, b, r;
            int op;
            op = int'($urandom_range(0, 31));
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case ($urandom_range(0, 5))
                0: a = MAX64 - 64'($urandom_range(0, 3));
                1: b = MIN64 + 64'($urandom_range(0, 3));
                2: b = a;
                3: a = 64'($urandom_range(0, 4));
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) b = 64'($urandom_range(0, 2)) << $urandom_range(0, 63);
            r = (op == 12 || op == 13 || op == 19 || op == 20) ? a - b : a + b;
            step($urandom_range(0, 7) != 0, op, a, b, r,
                 (op > 23) ? "R13" : "R2..R12 sweep");
        end
        step(0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        compare_now();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule